// File: doc/BRIEF.md
# Serial-In Parallel-Out Shifter with Output Latch

This block accepts a serial bit stream, moves it through a chain of shift stages, and copies the whole chain into a separate storage bank on request. The parallel pins are driven from that storage bank only, so a new word can be shifted in while the pins keep showing the previous one. A single storage clock edge then updates every parallel pin together.

The shift chain and the storage bank each run from their own rising-edge clock. An active-low clear empties the shift chain at once, without waiting for a clock edge, and leaves the storage bank untouched. An active-low output enable switches the parallel pins between driving the stored word and high impedance.

A cascade output always shows the last shift stage and is never tri-stated. Joining one device's cascade output to the next device's serial input builds a longer chain. The block has no state machine: its only sequencing is the order of the two clock edges. If both clocks come from one signal, the storage bank always holds the word the chain held just before that edge, which is one shift behind.

Top module: `slr_shift_latch`

## Requirements
- R1: While `clr_n` is low, every shift stage is 0 and `cascade_out` is 0. This takes effect as soon as `clr_n` falls, with no shift clock edge needed.
- R2: On a rising edge of `shift_clk` with `clr_n` high, stage 0 takes `ser_in` and each stage i (i ≥ 1) takes the previous value of stage i-1.
- R3: A rising edge of `shift_clk` while `clr_n` is low leaves every shift stage at 0.
- R4: On a rising edge of `store_clk`, the storage bank copies all shift stages. With `oe_n` low, `par_out[i]` shows stored stage i, so bit 0 is the most recently shifted-in value.
- R5: `cascade_out` always equals the last shift stage (`WIDTH-1`). It is driven even when `oe_n` is high.
- R6: With `oe_n` high, all `par_out` bits are high impedance. With `oe_n` low, they drive the stored word.
- R7: Taking `clr_n` low does not change the storage bank or `par_out`.
- R8: A `shift_clk` edge that has no `store_clk` edge leaves `par_out` unchanged.
- R9: If `shift_clk` and `store_clk` rise together, the storage bank captures the shift contents from just before that edge.
- R10: In a two-device chain, the second device's `ser_in` is fed from the first device's `cascade_out`. After 16 shifts and one storage edge, the first device shows the 8 newest bits and the second device shows the 8 older bits, each in R4 order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data into stage 0 |
| shift_clk | input | 1 | Shift chain clock, rising edge |
| store_clk | input | 1 | Storage bank clock, rising edge |
| clr_n | input | 1 | Asynchronous clear of the shift chain, active low |
| oe_n | input | 1 | Parallel output enable, active low |
| par_out | output | WIDTH | Tri-state parallel outputs from the storage bank |
| cascade_out | output | 1 | Last shift stage, for chaining |

## Verification
The bench builds two instances with the default `WIDTH` of 8 and chains them through `cascade_out`. This gives a 16-stage path, so the hand-over from the last stage of one device to stage 0 of the next is exercised, along with whole-chain loading (R10). One device's parallel bus has pull-ups and the other's has pull-downs. A released bus therefore reads as a known value that differs from the stored data. Random shift-only, store-only and tied-clock steps are mixed with directed checks of clear, output enable and store hold.

// File: rtl/slr_pkg.sv
package slr_pkg;
    // Default number of stages in one device
    localparam int unsigned SLR_DEF_WIDTH = 8;

    // Per-stage selection of the parallel pin driver
    typedef enum logic {
        DRV_HIZ   = 1'b0,
        DRV_VALUE = 1'b1
    } slr_drv_e;
endpackage

// File: rtl/slr_shift_chain.sv
module slr_shift_chain #(
    parameter int unsigned WIDTH = slr_pkg::SLR_DEF_WIDTH
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             din,
    output logic [WIDTH-1:0] stages
);
    localparam int unsigned TOP = WIDTH - 1;

    // Clear wins over the clock; new bit enters stage 0
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            stages <= '0;
        end else begin
            stages <= {stages[TOP-1:0], din};
        end
    end

    // R3: a shift edge during clear finds the chain empty
    p_clear_r3: assert property (@(posedge clk) !clr_n |-> stages == '0);

    // R2: each running edge moves the chain one place and inserts din
    p_shift_r2: assert property (@(posedge clk) disable iff (!clr_n)
        $past(clr_n) |-> stages == {$past(stages[TOP-1:0]), $past(din)});
endmodule

// File: rtl/slr_store_bank.sv
module slr_store_bank #(
    parameter int unsigned WIDTH = slr_pkg::SLR_DEF_WIDTH
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // No reset: the stored word survives a clear of the shift chain
    always_ff @(posedge clk) begin
        q <= d;
    end
endmodule

// File: rtl/slr_out_drv.sv
module slr_out_drv #(
    parameter int unsigned WIDTH = slr_pkg::SLR_DEF_WIDTH
) (
    input  logic             oe_n,
    input  logic [WIDTH-1:0] val,
    output logic [WIDTH-1:0] pins
);
    import slr_pkg::*;

    slr_drv_e mode;
    assign mode = oe_n ? DRV_HIZ : DRV_VALUE;

    for (genvar b = 0; b < WIDTH; b++) begin : g_pin
        assign pins[b] = (mode == DRV_VALUE) ? val[b] : 1'bz;
    end
endmodule

// File: rtl/slr_shift_latch.sv
module slr_shift_latch #(
    parameter int unsigned WIDTH = slr_pkg::SLR_DEF_WIDTH
) (
    input  logic             ser_in,
    input  logic             shift_clk,
    input  logic             store_clk,
    input  logic             clr_n,
    input  logic             oe_n,
    output logic [WIDTH-1:0] par_out,
    output logic             cascade_out
);
    localparam int unsigned LAST = WIDTH - 1;

    logic [WIDTH-1:0] chain_q;
    logic [WIDTH-1:0] held_q;

    slr_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk    (shift_clk),
        .clr_n  (clr_n),
        .din    (ser_in),
        .stages (chain_q)
    );

    slr_store_bank #(.WIDTH(WIDTH)) u_bank (
        .clk (store_clk),
        .d   (chain_q),
        .q   (held_q)
    );

    slr_out_drv #(.WIDTH(WIDTH)) u_drv (
        .oe_n (oe_n),
        .val  (held_q),
        .pins (par_out)
    );

    // The cascade pin is never tri-stated
    assign cascade_out = chain_q[LAST];

    // R4: each storage edge leaves the bank holding the chain seen at that edge
    p_capture_r4: assert property (@(posedge store_clk) disable iff (!clr_n)
        1'b1 |=> held_q == $past(chain_q));

    // R5: the cascade pin follows the stage before last, one shift later
    p_cascade_r5: assert property (@(posedge shift_clk) disable iff (!clr_n)
        $past(clr_n) |-> cascade_out == $past(chain_q[LAST-1]));
endmodule

// File: tb/sim_slr_shift_latch.sv
`timescale 1ns/1ps
module sim_slr_shift_latch;
    localparam int W = 8;
    localparam int HALF = 10; // 50 MHz pulse timing

    logic ser_in, shift_clk, store_clk, clr_n, oe_n;
    wire  [W-1:0] bus0, bus1;
    wire  casc0, casc1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [2*W-1:0] exp_chain;
    logic [W-1:0]   exp_st0, exp_st1;

    for (genvar g = 0; g < W; g++) begin : g_pull
        pullup   (bus0[g]);
        pulldown (bus1[g]);
    end

    slr_shift_latch #(.WIDTH(W)) u0 (
        .ser_in(ser_in), .shift_clk(shift_clk), .store_clk(store_clk),
        .clr_n(clr_n), .oe_n(oe_n), .par_out(bus0), .cascade_out(casc0));

    slr_shift_latch #(.WIDTH(W)) u1 (
        .ser_in(casc0), .shift_clk(shift_clk), .store_clk(store_clk),
        .clr_n(clr_n), .oe_n(oe_n), .par_out(bus1), .cascade_out(casc1));

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Expected pin values from R4/R6 and the bus pull direction
    function automatic logic [W-1:0] pins_exp(input logic [W-1:0] st, input logic pull_hi);
        return oe_n ? {W{pull_hi}} : st;
    endfunction

    task automatic check_all(input string req);
        chk({req, " bus0"}, bus0, pins_exp(exp_st0, 1'b1));
        chk({req, " bus1"}, bus1, pins_exp(exp_st1, 1'b0));
        chk({req, " casc0"}, {{(W-1){1'b0}}, casc0}, {{(W-1){1'b0}}, exp_chain[W-1]});
        chk({req, " casc1"}, {{(W-1){1'b0}}, casc1}, {{(W-1){1'b0}}, exp_chain[2*W-1]});
    endtask

    // do_sh / do_st select which clocks pulse; both set means tied clocks
    task automatic pulse(input logic do_sh, input logic do_st, input logic b);
        ser_in = b;
        #(HALF/2);
        if (do_sh) shift_clk = 1'b1;
        if (do_st) store_clk = 1'b1;
        // R9: the bank sees the pre-edge chain
        if (do_st) begin
            exp_st0 = exp_chain[W-1:0];
            exp_st1 = exp_chain[2*W-1:W];
        end
        if (do_sh && clr_n) exp_chain = {exp_chain[2*W-2:0], b};
        #HALF;
        shift_clk = 1'b0;
        store_clk = 1'b0;
        #(HALF/2);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2*W-1:0] pat;
        logic [W-1:0] keep0, keep1;
        void'($urandom(32'd1234));
        ser_in = 0; shift_clk = 0; store_clk = 0; clr_n = 0; oe_n = 0;
        exp_chain = '0;
        #7;
        // R1: clear state, then store it to make the bank known
        pulse(1'b0, 1'b1, 1'b0);
        check_all("R1 reset");
        // R3: shifting during clear keeps the chain empty
        pulse(1'b1, 1'b0, 1'b1);
        pulse(1'b0, 1'b1, 1'b0);
        check_all("R3 clock during clear");
        clr_n = 1; #5;

        // R10 and R2: 16 shifts, one store, across the chain
        pat = 16'hB38D;
        for (int i = 0; i < 2*W; i++) pulse(1'b1, 1'b0, pat[2*W-1-i]);
        pulse(1'b0, 1'b1, 1'b0);
        chk("R10 first device", bus0, pat[W-1:0]);
        chk("R10 second device", bus1, pat[2*W-1:W]);
        check_all("R2 R4 chain");

        // R8: shifting alone leaves the pins alone
        keep0 = bus0; keep1 = bus1;
        for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0, 1'b1);
        chk("R8 hold bus0", bus0, keep0);
        chk("R8 hold bus1", bus1, keep1);
        check_all("R8");

        // R6 and R5: release the buses, cascade stays driven
        oe_n = 1; #5;
        chk("R6 bus0 released", bus0, 8'hFF);
        chk("R6 bus1 released", bus1, 8'h00);
        check_all("R5 cascade with oe_n high");
        pulse(1'b0, 1'b1, 1'b0);
        check_all("R6 store while released");
        oe_n = 0; #5;
        check_all("R6 re-enabled");

        // R7: clear leaves storage untouched, R1 takes effect at once
        keep0 = bus0; keep1 = bus1;
        clr_n = 0; #3;
        exp_chain = '0;
        chk("R7 bus0", bus0, keep0);
        chk("R7 bus1", bus1, keep1);
        check_all("R1 async clear");
        pulse(1'b1, 1'b0, 1'b1);
        clr_n = 1; #5;

        // R9: tied clocks, directed
        pulse(1'b1, 1'b0, 1'b1);
        pulse(1'b1, 1'b1, 1'b1);
        chk("R9 tied lag", bus0, 8'h01);
        check_all("R9 tied");

        // Random mix of shift, store, tied, enable toggles
        for (int k = 0; k < 400; k++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 5)       pulse(1'b1, 1'b0, 1'($urandom_range(0, 1)));
            else if (op < 7)  pulse(1'b0, 1'b1, 1'b0);
            else if (op < 9)  pulse(1'b1, 1'b1, 1'($urandom_range(0, 1)));
            else begin oe_n = ~oe_n; #5; end
            check_all("R2 R4 R9 random");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule